// File: doc/BRIEF.md
# Graphic LCD Segment Driver Host Interface

This block is the processor-facing side of a segment driver that serves 64 columns by 8 pages of one-bit pixels. A host reaches it over a classic strobed 8-bit bus. The bus carries three chip selects, a register/data select (`rs`), a read/write select (`rw`) and an enable strobe (`e_strobe`). The block samples these pins synchronously to `clk`. It acts on each transfer when it sees the falling edge of the strobe. Instructions set the page, set the column, set the display start line and switch the display on or off. Data writes store a byte in an internal 512-byte display RAM. Data reads return bytes from that RAM through a one-deep output register.

The bus is a strobe protocol. It has no valid/ready handshake and no back-pressure. Flow control is the busy flag. After every accepted instruction, data write or data read, the block stays busy for `BUSY_CYC` clock cycles and ignores every transfer except status reads. A host must either poll the status byte or space its transfers. The data bus is modelled as tri-state: `db_o` carries the value and `db_oe` enables the pad driver.

Top module: `glcd_seg_host_if`

## Requirements
- R1: A transfer acts only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1 all hold. An unselected transfer changes no state, and `db_oe` stays 0 while it is in progress.
- R2: The transfer kind is decoded from `rs` and `rw` as follows:
  - `rs`=0, `rw`=0: instruction.
  - `rs`=0, `rw`=1: status read.
  - `rs`=1, `rw`=0: data write.
  - `rs`=1, `rw`=1: data read.
- R3: A write or instruction takes effect on the clock edge where the strobe is first seen low after being high, using the `db_i`, `rs`, `rw` and select values sampled at that edge. On a selected read, `db_oe`=1 and `db_o` is valid while `e_strobe` is high.
- R4: A data read drives the current output-register value. At its falling edge it loads RAM[page][column] into that register. The first read after setting an address therefore returns stale data (a dummy read). The output register is 0 after reset.
- R5: The status byte places busy at bit 7, display-off at bit 5 and reset-active at bit 4. All other bits are 0. A status read needs no dummy read.
- R6: Each accepted instruction, data write or data read makes `busy` high for exactly `BUSY_CYC` (default 2) cycles after its falling-edge cycle. A status read never starts busy.
- R7: An instruction, data write or data read whose falling edge comes while `busy` is high is ignored completely. It makes no state change, no column step and no busy restart.
- R8: The page changes only by instruction and never counts. The column steps by one after each accepted data read or write and wraps from 63 to 0.
- R9: Instruction codes are as follows. Any other byte is ignored.
  - 0x3E: display off.
  - 0x3F: display on.
  - 0x40|c: set column c (6 bits).
  - 0xB8|p: set page p (3 bits).
  - 0xC0|s: set start line s (6 bits).
- R10: While `rst_n` is low, `disp_on` and `start_line` are 0, and page, column and output register are cleared. Only status reads are answered, and a data read leaves `db_oe` at 0.
- R11: The `disp_on` and `start_line` outputs follow the accepted instructions from the clock edge of their falling strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and internal clock |
| rst_n | input | 1 | Active-low reset; also reported in status |
| e_strobe | input | 1 | Bus enable strobe; transfers act on its falling edge |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| rs | input | 1 | 0 = instruction/status, 1 = display data |
| rw | input | 1 | 0 = write, 1 = read |
| db_i | input | 8 | Bus data from host |
| db_o | output | 8 | Bus data to host |
| db_oe | output | 1 | Drive enable for the bus pads |
| busy | output | 1 | Busy flag, same as status bit 7 |
| disp_on | output | 1 | Display enable state |
| start_line | output | 6 | Display start line register |

## Verification
A wrong column or page value stays hidden until data is read back. It then shows up as a byte shifted by one or more positions, usually two transfers later, because of the dummy-read stage. A stuck or lengthened busy count shows up one cycle after an access, in status bit 7. It also shows up as a following instruction that is dropped or wrongly accepted, which `disp_on` and `start_line` reveal on the next cycle. Gating faults in the selects or in the reset check appear at once, on `db_oe` while the strobe is high.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_INSTR,
    ACC_STATUS,
    ACC_WRITE,
    ACC_READ
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] data;
  } acc_t;

  // status byte bit positions (host software decodes these)
  localparam int ST_BUSY = 7;
  localparam int ST_OFF  = 5;
  localparam int ST_RST  = 4;

  // instruction opcode prefixes
  localparam logic [6:0] OPC_DISP  = 7'b0011111; // bits 7:1
  localparam logic [1:0] OPC_COL   = 2'b01;      // bits 7:6
  localparam logic [4:0] OPC_PAGE  = 5'b10111;   // bits 7:3
  localparam logic [1:0] OPC_START = 2'b11;      // bits 7:6

endpackage

// File: rtl/glcd_bus_sampler.sv
module glcd_bus_sampler
  import glcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       e_strobe,
  input  logic       cs1_n,
  input  logic       cs2_n,
  input  logic       cs3,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_i,
  output logic       sel,
  output acc_t       acc
);

  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= e_strobe;
  end

  assign sel = !cs1_n && !cs2_n && cs3;

  always_comb begin
    acc.data = db_i;
    acc.kind = ACC_NONE;
    if (strobe_q && !e_strobe && sel) begin
      unique case ({rs, rw})
        2'b00: acc.kind = ACC_INSTR;
        2'b01: acc.kind = ACC_STATUS;
        2'b10: acc.kind = ACC_WRITE;
        default: acc.kind = ACC_READ;
      endcase
    end
  end

endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
  import glcd_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int LINES    = 64,
  parameter int BUSY_CYC = 2,
  localparam int COL_W   = $clog2(COLS),
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int LINE_W  = $clog2(LINES),
  localparam int BCNT_W  = $clog2(BUSY_CYC + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] start_line,
  output logic              disp_on,
  output logic              busy,
  output logic              wr_stb,
  output logic              rd_stb
);

  logic [BCNT_W-1:0] bcnt;
  logic              take;
  logic              is_instr;

  assign busy     = (bcnt != '0);
  assign take     = !busy && (acc.kind == ACC_INSTR || acc.kind == ACC_WRITE ||
                              acc.kind == ACC_READ);
  assign is_instr = take && (acc.kind == ACC_INSTR);
  assign wr_stb   = take && (acc.kind == ACC_WRITE);
  assign rd_stb   = take && (acc.kind == ACC_READ);

  // busy window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (take) bcnt <= BCNT_W'(BUSY_CYC);
    else if (busy) bcnt <= bcnt - 1'b1;
  end

  // instruction-loaded registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_on    <= 1'b0;
      start_line <= '0;
      page       <= '0;
    end else if (is_instr) begin
      if (acc.data[7:1] == OPC_DISP)
        disp_on <= acc.data[0];
      else if (acc.data[7:3] == OPC_PAGE)
        page <= acc.data[PAGE_W-1:0];
      else if (acc.data[7:6] == OPC_START)
        start_line <= acc.data[LINE_W-1:0];
    end
  end

  // column counter: loaded by instruction, stepped by data access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
    end else if (is_instr && acc.data[7:6] == OPC_COL) begin
      col <= acc.data[COL_W-1:0];
    end else if (wr_stb || rd_stb) begin
      if (col == COL_W'(COLS - 1)) col <= '0;
      else                         col <= col + 1'b1;
    end
  end

endmodule

// File: rtl/glcd_dram.sv
module glcd_dram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/glcd_rdpath.sv
module glcd_rdpath
  import glcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic [7:0] ram_q,
  input  logic       e_strobe,
  input  logic       sel,
  input  logic       rs,
  input  logic       rw,
  input  logic       busy,
  input  logic       disp_on,
  output logic [7:0] db_o,
  output logic       db_oe
);

  logic [7:0] out_q;
  logic [7:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (rd_stb) out_q <= ram_q;
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_OFF]  = !disp_on;
    status[ST_RST]  = !rst_n;
  end

  assign db_oe = e_strobe && sel && rw && (rst_n || !rs);
  assign db_o  = rs ? out_q : status;

endmodule

// File: rtl/glcd_seg_host_if.sv
module glcd_seg_host_if
  import glcd_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int LINES    = 64,
  parameter int BUSY_CYC = 2,
  localparam int COL_W   = $clog2(COLS),
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int LINE_W  = $clog2(LINES),
  localparam int DEPTH   = COLS * PAGES
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_strobe,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic              rs,
  input  logic              rw,
  input  logic [7:0]        db_i,
  output logic [7:0]        db_o,
  output logic              db_oe,
  output logic              busy,
  output logic              disp_on,
  output logic [LINE_W-1:0] start_line
);

  acc_t              acc;
  logic              sel;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic              wr_stb;
  logic              rd_stb;
  logic [7:0]        ram_q;

  glcd_bus_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_strobe (e_strobe),
    .cs1_n    (cs1_n),
    .cs2_n    (cs2_n),
    .cs3      (cs3),
    .rs       (rs),
    .rw       (rw),
    .db_i     (db_i),
    .sel      (sel),
    .acc      (acc)
  );

  glcd_ctrl #(
    .COLS     (COLS),
    .PAGES    (PAGES),
    .LINES    (LINES),
    .BUSY_CYC (BUSY_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .page       (page),
    .col        (col),
    .start_line (start_line),
    .disp_on    (disp_on),
    .busy       (busy),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb)
  );

  glcd_dram #(
    .DEPTH (DEPTH),
    .DW    (8)
  ) u_dram (
    .clk   (clk),
    .we    (wr_stb),
    .addr  ({page, col}),
    .wdata (acc.data),
    .rdata (ram_q)
  );

  glcd_rdpath u_rdpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .ram_q    (ram_q),
    .e_strobe (e_strobe),
    .sel      (sel),
    .rs       (rs),
    .rw       (rw),
    .busy     (busy),
    .disp_on  (disp_on),
    .db_o     (db_o),
    .db_oe    (db_oe)
  );

endmodule

// File: rtl/glcd_seg_host_if_chk.sv
module glcd_seg_host_if_chk #(
  parameter int LINE_W = 6
)(
  input logic              clk,
  input logic              rst_n,
  input logic              e_strobe,
  input logic              cs1_n,
  input logic              cs2_n,
  input logic              cs3,
  input logic              rs,
  input logic              rw,
  input logic [7:0]        db_o,
  input logic              db_oe,
  input logic              busy,
  input logic              disp_on,
  input logic [LINE_W-1:0] start_line
);

  logic strobe_d;
  logic chip_sel;
  logic edge_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b0;
    else        strobe_d <= e_strobe;
  end

  assign chip_sel = !cs1_n && !cs2_n && cs3;
  assign edge_sel = strobe_d && !e_strobe && chip_sel;

  assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |-> !db_oe);

  assert_status_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe && !rs) |-> (db_o[3:0] == 4'h0 && db_o[6] == 1'b0 &&
                        db_o[4] == 1'b0 && db_o[7] == busy));

  assert_access_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && !busy && !(!rs && rw)) |=> busy);

  assert_busy_drops_instr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && busy) |=> ($stable(disp_on) && $stable(start_line)));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!disp_on && start_line == '0 && !busy));

  assert_start_only_by_instr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_sel && !rs && !rw) |=> $stable(start_line));

endmodule

bind glcd_seg_host_if glcd_seg_host_if_chk #(.LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .e_strobe   (e_strobe),
  .cs1_n      (cs1_n),
  .cs2_n      (cs2_n),
  .cs3        (cs3),
  .rs         (rs),
  .rw         (rw),
  .db_o       (db_o),
  .db_oe      (db_oe),
  .busy       (busy),
  .disp_on    (disp_on),
  .start_line (start_line)
);

// File: tb/glcd_seg_host_if_bench.sv
module glcd_seg_host_if_bench;

  localparam int BUSY_CYC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e_strobe = 1'b0;
  logic       cs1_n = 1'b0;
  logic       cs2_n = 1'b0;
  logic       cs3 = 1'b1;
  logic       rs = 1'b0;
  logic       rw = 1'b0;
  logic [7:0] db_i = 8'h00;
  logic [7:0] db_o;
  logic       db_oe;
  logic       busy;
  logic       disp_on;
  logic [5:0] start_line;

  always #5 clk = ~clk;

  glcd_seg_host_if #(.BUSY_CYC(BUSY_CYC)) u_glcd_seg_host_if (
    .clk (clk), .rst_n (rst_n), .e_strobe (e_strobe),
    .cs1_n (cs1_n), .cs2_n (cs2_n), .cs3 (cs3), .rs (rs), .rw (rw),
    .db_i (db_i), .db_o (db_o), .db_oe (db_oe), .busy (busy),
    .disp_on (disp_on), .start_line (start_line)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] m_mem [512];
  logic [2:0] m_page;
  logic [5:0] m_col;
  logic [7:0] m_out;
  logic       m_on;
  logic [5:0] m_start;

  // scoreboard queues
  logic       q_oe  [$];
  logic [7:0] q_val [$];
  string      q_tag [$];
  logic       probe = 1'b0;

  task automatic model_reset();
    m_page = '0; m_col = '0; m_out = '0; m_on = 1'b0; m_start = '0;
  endtask

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: samples the bus while the strobe is high
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (probe && q_oe.size() > 0) begin
        logic       e_oe;
        logic [7:0] e_val;
        string      t;
        e_oe = q_oe.pop_front();
        e_val = q_val.pop_front();
        t = q_tag.pop_front();
        n_checks++;
        if (db_oe !== e_oe || (e_oe && db_o !== e_val)) begin
          n_fail++;
          $display("FAIL %s: got oe=%0b data=%02h expected oe=%0b data=%02h",
                   t, db_oe, db_o, e_oe, e_val);
        end
      end
    end
  end

  // driver: one bus transfer; exp_busy states whether busy is expected during it
  task automatic bus_op(input logic rs_v, input logic rw_v, input logic [7:0] d,
                        input string tag, input bit exp_busy = 1'b0,
                        input bit fast = 1'b0, input logic c1n = 1'b0,
                        input logic c2n = 1'b0, input logic c3 = 1'b1);
    logic sel_v;
    sel_v = !c1n && !c2n && c3;
    @(negedge clk);
    cs1_n = c1n; cs2_n = c2n; cs3 = c3; rs = rs_v; rw = rw_v; db_i = d;
    e_strobe = 1'b1;
    if (rw_v) begin
      if (!sel_v || (rs_v && !rst_n)) begin
        q_oe.push_back(1'b0); q_val.push_back(8'h00);
      end else if (!rs_v) begin
        q_oe.push_back(1'b1);
        q_val.push_back({exp_busy, 1'b0, !m_on, !rst_n, 4'h0});
      end else begin
        q_oe.push_back(1'b1); q_val.push_back(m_out);
      end
      q_tag.push_back(tag);
      probe = 1'b1;
    end
    @(negedge clk);
    probe = 1'b0;
    e_strobe = 1'b0;
    if (sel_v && rst_n && !exp_busy && !(!rs_v && rw_v)) begin
      if (!rs_v) begin
        if (d[7:1] == 7'b0011111)   m_on = d[0];
        else if (d[7:6] == 2'b01)   m_col = d[5:0];
        else if (d[7:3] == 5'b10111) m_page = d[2:0];
        else if (d[7:6] == 2'b11)   m_start = d[5:0];
      end else begin
        if (rw_v) m_out = m_mem[{m_page, m_col}];
        else      m_mem[{m_page, m_col}] = d;
        m_col = m_col + 1'b1;
      end
    end
    if (!fast) repeat (BUSY_CYC + 2) @(posedge clk);
  endtask

  task automatic check_outputs(input string tag);
    @(negedge clk);
    check({7'b0, disp_on}, {7'b0, m_on}, {tag, " disp_on"});
    check({2'b0, start_line}, {2'b0, m_start}, {tag, " start_line"});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    // reset state and status during reset (R10, R5)
    @(negedge clk);
    check({7'b0, busy}, 8'h00, "R6 busy in reset");
    check({7'b0, db_oe}, 8'h00, "R3 idle bus");
    check_outputs("R10 reset");
    bus_op(1'b0, 1'b1, 8'h00, "R5 status in reset");
    bus_op(1'b1, 1'b1, 8'h00, "R10 data read blocked in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    bus_op(1'b0, 1'b1, 8'h00, "R5 status after reset");
    // instructions (R9, R11, R2)
    bus_op(1'b0, 1'b0, 8'h3F, "R9 on");
    check_outputs("R11 display on");
    bus_op(1'b0, 1'b0, 8'hC5, "R9 start");
    check_outputs("R11 start line");
    bus_op(1'b0, 1'b0, 8'h17, "R9 unknown code");
    check_outputs("R9 unknown ignored");
    bus_op(1'b0, 1'b1, 8'h00, "R5 status display on");

    // writes with column wrap in page 3 (R8, R3)
    bus_op(1'b0, 1'b0, 8'hBB, "R9 page3");
    bus_op(1'b0, 1'b0, 8'h7E, "R9 col62");
    bus_op(1'b1, 1'b0, 8'hA1, "R3 write");
    bus_op(1'b1, 1'b0, 8'hA2, "R3 write");
    bus_op(1'b1, 1'b0, 8'hA3, "R8 write after wrap");
    bus_op(1'b0, 1'b0, 8'hBC, "R9 page4");
    bus_op(1'b0, 1'b0, 8'h40, "R9 col0");
    bus_op(1'b1, 1'b0, 8'h5C, "R8 write other page");

    // read back page 3 with dummy read (R4, R8)
    bus_op(1'b0, 1'b0, 8'hBB, "R9 page3");
    bus_op(1'b0, 1'b0, 8'h7E, "R9 col62");
    bus_op(1'b1, 1'b1, 8'h00, "R4 dummy read");
    bus_op(1'b1, 1'b1, 8'h00, "R4 read col62");
    bus_op(1'b1, 1'b1, 8'h00, "R8 read col63");
    bus_op(1'b1, 1'b1, 8'h00, "R8 read col0 after wrap");
    bus_op(1'b1, 1'b1, 8'h00, "R8 page held");

    // busy window and dropped transfers (R6, R7)
    bus_op(1'b1, 1'b0, 8'h99, "R6 write", 1'b0, 1'b1);
    bus_op(1'b0, 1'b1, 8'h00, "R6 status while busy", 1'b1, 1'b1);
    @(negedge clk);
    check({7'b0, busy}, 8'h00, "R6 busy length");
    bus_op(1'b1, 1'b0, 8'h11, "R7 write", 1'b0, 1'b1);
    bus_op(1'b0, 1'b0, 8'h3E, "R7 off while busy", 1'b1, 1'b0);
    check_outputs("R7 instruction dropped");
    bus_op(1'b0, 1'b0, 8'hC9, "R7 start", 1'b0, 1'b1);
    bus_op(1'b1, 1'b0, 8'h77, "R7 write while busy", 1'b1, 1'b0);
    check_outputs("R7 start accepted");
    bus_op(1'b0, 1'b1, 8'h00, "R6 status a", 1'b0, 1'b1);
    bus_op(1'b0, 1'b1, 8'h00, "R6 status does not set busy", 1'b0, 1'b0);
    // the dropped write must not have landed: col after 0x11 write is next
    bus_op(1'b0, 1'b0, 8'hBB, "R9 page3");
    bus_op(1'b0, 1'b0, 8'h41, "R9 col1");
    bus_op(1'b1, 1'b1, 8'h00, "R4 dummy");
    bus_op(1'b1, 1'b1, 8'h00, "R7 location untouched");
    bus_op(1'b1, 1'b1, 8'h00, "R7 location untouched");

    // chip select gating (R1)
    bus_op(1'b0, 1'b0, 8'h3E, "R1 off unselected", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    bus_op(1'b0, 1'b0, 8'hC1, "R1 start unselected", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_outputs("R1 unselected instr");
    bus_op(1'b0, 1'b1, 8'h00, "R1 read unselected", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    bus_op(1'b0, 1'b0, 8'h42, "R9 col2");
    bus_op(1'b1, 1'b0, 8'hEE, "R1 write unselected", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_op(1'b1, 1'b1, 8'h00, "R1 dummy");
    bus_op(1'b1, 1'b1, 8'h00, "R1 write had no effect");

    // reset mid-run (R10)
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    check_outputs("R10 reset mid-run");
    bus_op(1'b1, 1'b0, 8'h66, "R10 write in reset");
    bus_op(1'b0, 1'b0, 8'h3F, "R10 instr in reset");
    check_outputs("R10 instr ignored");
    bus_op(1'b1, 1'b1, 8'h00, "R10 read in reset");
    bus_op(1'b0, 1'b1, 8'h00, "R10 status in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    bus_op(1'b0, 1'b1, 8'h00, "R10 status after release");
    bus_op(1'b1, 1'b1, 8'h00, "R10 output register cleared");
    bus_op(1'b1, 1'b1, 8'h00, "R10 write in reset dropped");

    repeat (4) @(posedge clk);
    if (q_oe.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_oe.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule